// File: doc/BRIEF.md
# Period-Timed Delta-Sigma Audio Modulator

This block converts a stream of signed audio samples into a one-bit pulse-density signal. A 16-bit counter climbs from zero to a programmable period value and then restarts at zero. Each restart sets the sample rate: it moves the buffered sample into the modulator and, one cycle later, raises a one-cycle request. Software or a DMA channel answers the request with the next sample.

Each sample is sixteen bits wide and is written one byte at a time. The low byte is written first and is parked in a holding register. The high-byte write joins both bytes into a complete buffered sample. The two least significant bits are discarded, which leaves fourteen bits of effective resolution.

A first-order error-feedback loop runs every clock cycle. Its accumulator is seventeen bits wide. The quantised output bit is the inverted accumulator sign, and positive or negative full scale is fed back according to that bit. Clearing the enable holds the output low and clears the accumulator.

The intended bring-up order is as follows:
1. Stop the counter.
2. Clear the counter.
3. Program the period.
4. Preload a first sample, or zero.
5. Start counting.
6. Enable the modulator.

Top module: `dsm_audio_mod`

## Requirements
- R1: Following reset the count reads 0, `sample_req` is 0, `pdm_out` is 0, the stored period is 0xFFFF and every sample register is zero.
- R2: While `tmr_run` is 1 and `cnt_clr` is 0, the count rises by one per cycle. When it equals the period it becomes 0 on the next cycle. While `tmr_run` is 0 the count holds. `cnt_clr` forces the count to 0 and takes priority over counting. `period_we` stores `period_in` as the new period.
- R3: `sample_req` is 1 for exactly the cycle after an edge at which the counter wrapped (running, not clearing, count equal to period). With a period of 0 it therefore stays 1 continuously.
- R4: A `samp_lo_we` write stores `samp_byte` in a holding register only and changes no buffered or modulated value. A `samp_hi_we` write forms the buffered sample {`samp_byte`, held low byte}.
- R5: Bits 1:0 of every sample are treated as zero. Two samples that differ only there produce identical output.
- R6: While running, the modulated sample is replaced by the buffered sample only at a wrap edge. While stopped, it takes the buffered value one edge after the buffer changes.
- R7: If a high-byte write and a wrap fall on the same edge, the modulated sample becomes the buffer value from before that write. The new sample takes effect at the following wrap.
- R8: While `mod_en` is 1, each edge computes y = (acc ≥ 0), sets `pdm_out` to y and updates acc ← acc + x − 32768·y + 32768·(1−y). Here x is the signed modulated sample.
- R9: While `mod_en` is 0, `pdm_out` is 0 and the accumulator is cleared. A zero sample after re-enabling therefore yields exactly 32 ones in 64 cycles.
- R10: The accumulator update never overflows its 17-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_run | input | 1 | 1 = counter runs in modulo mode |
| cnt_clr | input | 1 | Clears the counter to zero |
| period_we | input | 1 | Stores `period_in` as period |
| period_in | input | 16 | Period value (wrap count) |
| samp_lo_we | input | 1 | Low sample byte write strobe |
| samp_hi_we | input | 1 | High sample byte write strobe, completes a sample |
| samp_byte | input | 8 | Sample byte data |
| mod_en | input | 1 | Modulator enable |
| tmr_cnt | output | 16 | Current count |
| sample_req | output | 1 | One-cycle request for the next sample |
| pdm_out | output | 1 | Pulse-density output bit |

## Verification
Two events can land on the same edge: a high-byte write that completes a sample, and the counter wrap that transfers the buffer to the modulator. The bench provokes this by watching the count until it equals the period and then asserting the high-byte strobe for exactly that edge. With a period of zero, every write collides with a wrap. The result is judged by cycle-accurate comparison of `pdm_out` against an arithmetic model. In that model, the colliding edge loads the old buffer and the new sample reaches the output only one period later.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int SAMP_W  = 16;
  localparam int DROP_W  = 2;
  localparam int CNT_W   = 16;
  localparam int ACC_W   = SAMP_W + 1;
  localparam int BYTE_W  = SAMP_W / 2;

  // Force the unused low sample bits to zero.
  function automatic logic [SAMP_W-1:0] drop_lsbs(input logic [SAMP_W-1:0] s);
    return {s[SAMP_W-1:DROP_W], {DROP_W{1'b0}}};
  endfunction

  // Quantiser: one when the accumulator is non-negative.
  function automatic logic dsm_bit(input logic [ACC_W-1:0] a);
    return ~a[ACC_W-1];
  endfunction

  // Accumulator step, one bit wider than the accumulator so overflow is visible.
  function automatic logic [ACC_W:0] dsm_next(input logic [ACC_W-1:0] a,
                                             input logic [SAMP_W-1:0] x);
    logic [ACC_W:0] ae;
    logic [ACC_W:0] xe;
    logic [ACC_W:0] fs;
    ae = {a[ACC_W-1], a};
    xe = {{2{x[SAMP_W-1]}}, x};
    fs = (ACC_W+1)'(1) << (SAMP_W-1);
    return dsm_bit(a) ? (ae + xe - fs) : (ae + xe + fs);
  endfunction
endpackage

// File: rtl/dsm_period_timer.sv
module dsm_period_timer
  import dsm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic         per_we,
  input  logic [W-1:0] per_in,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] per_q;

  assign wrap = run && !clr && (cnt_q == per_q);
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '1;
    end else begin
      if (per_we) per_q <= per_in;
      if (clr)       cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else if (run)  cnt_q <= cnt_q + W'(1);
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !wrap) |=> (cnt_q == $past(cnt_q) + W'(1))); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/dsm_sample_buf.sv
module dsm_sample_buf
  import dsm_pkg::*;
#(
  parameter int SW = SAMP_W,
  localparam int BW = SW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [BW-1:0] byte_in,
  input  logic          load,
  output logic [SW-1:0] act
);
  logic [BW-1:0] lo_q;
  logic [SW-1:0] buf_q;
  logic [SW-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (lo_we) lo_q  <= byte_in;
      if (hi_we) buf_q <= drop_lsbs({byte_in, lo_q});
      if (load)  act_q <= buf_q;
    end
  end

  assign act = act_q;

  AST_LO_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !hi_we) |=> $stable(buf_q)); // R4
  AST_ACT_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q)); // R6
  AST_COLLIDE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && hi_we) |=> (act_q == $past(buf_q))); // R7
endmodule

// File: rtl/dsm_accum.sv
module dsm_accum
  import dsm_pkg::*;
#(
  parameter int SW = SAMP_W,
  localparam int AW = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [SW-1:0] x,
  output logic          pdm
);
  logic [AW-1:0] acc_q;
  logic [AW:0]   sum_wide;
  logic          pdm_q;

  assign sum_wide = dsm_next(acc_q, x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      pdm_q <= 1'b0;
    end else if (!en) begin
      acc_q <= '0;
      pdm_q <= 1'b0;
    end else begin
      acc_q <= sum_wide[AW-1:0];
      pdm_q <= dsm_bit(acc_q);
    end
  end

  assign pdm = pdm_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (sum_wide[AW] == sum_wide[AW-1])); // R10
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pdm_q && acc_q == '0)); // R9
  AST_LSBS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    x[DROP_W-1:0] == '0); // R5
endmodule

// File: rtl/dsm_audio_mod.sv
module dsm_audio_mod
  import dsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_run,
  input  logic              cnt_clr,
  input  logic              period_we,
  input  logic [CNT_W-1:0]  period_in,
  input  logic              samp_lo_we,
  input  logic              samp_hi_we,
  input  logic [BYTE_W-1:0] samp_byte,
  input  logic              mod_en,
  output logic [CNT_W-1:0]  tmr_cnt,
  output logic              sample_req,
  output logic              pdm_out
);
  logic              tmr_wrap;
  logic              act_load;
  logic [SAMP_W-1:0] act_sample;
  logic              req_q;

  dsm_period_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .clr(cnt_clr),
    .per_we(period_we), .per_in(period_in), .cnt(tmr_cnt), .wrap(tmr_wrap)
  );

  // Transfer on wrap while running; track the buffer while stopped (preload).
  assign act_load = !tmr_run || tmr_wrap;

  dsm_sample_buf #(.SW(SAMP_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .lo_we(samp_lo_we), .hi_we(samp_hi_we),
    .byte_in(samp_byte), .load(act_load), .act(act_sample)
  );

  dsm_accum #(.SW(SAMP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(mod_en), .x(act_sample), .pdm(pdm_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= tmr_wrap;
  end

  assign sample_req = req_q;

  AST_REQ_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> sample_req); // R3
  AST_NO_REQ_WITHOUT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wrap |=> !sample_req); // R3
endmodule

// File: tb/dsm_audio_mod_tb.sv
module dsm_audio_mod_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_run = 1'b0, cnt_clr = 1'b0, period_we = 1'b0;
  logic [15:0] period_in = '0;
  logic        samp_lo_we = 1'b0, samp_hi_we = 1'b0;
  logic [7:0]  samp_byte = '0;
  logic        mod_en = 1'b0;
  logic [15:0] tmr_cnt;
  logic        sample_req, pdm_out;

  int checks = 0;
  int errors = 0;
  string tag = "R8";
  bit done = 1'b0;

  always #5 clk = ~clk;

  dsm_audio_mod u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_run(tmr_run), .cnt_clr(cnt_clr),
    .period_we(period_we), .period_in(period_in), .samp_lo_we(samp_lo_we),
    .samp_hi_we(samp_hi_we), .samp_byte(samp_byte), .mod_en(mod_en),
    .tmr_cnt(tmr_cnt), .sample_req(sample_req), .pdm_out(pdm_out)
  );

  // Arithmetic reference built from the requirements.
  int          m_cnt, m_per, m_acc;
  logic [7:0]  m_lo;
  logic [15:0] m_buf, m_act;
  bit          m_req, m_pdm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 65535; m_acc = 0; m_lo = 0; m_buf = 0; m_act = 0;
      m_req = 0; m_pdm = 0;
    end else begin
      bit wr;
      int x;
      bit y;
      wr = tmr_run && !cnt_clr && (m_cnt == m_per);
      x  = int'($signed(m_act));
      y  = (m_acc >= 0);
      if (mod_en) begin
        m_acc = y ? (m_acc + x - 32768) : (m_acc + x + 32768);
        m_pdm = y;
      end else begin
        m_acc = 0;
        m_pdm = 0;
      end
      if (!tmr_run || wr) m_act = m_buf;
      if (samp_hi_we) m_buf = {samp_byte, m_lo} & 16'hFFFC;
      if (samp_lo_we) m_lo = samp_byte;
      m_req = wr;
      if (cnt_clr || wr) m_cnt = 0;
      else if (tmr_run) m_cnt = m_cnt + 1;
      if (period_we) m_per = int'(period_in);
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " count"}, int'(tmr_cnt), m_cnt);        // R2
    chk({tag, " req"}, int'(sample_req), int'(m_req)); // R3
    chk({tag, " pdm"}, int'(pdm_out), int'(m_pdm));    // R8
  endtask

  task automatic write_sample(input logic [15:0] s, input bit collide);
    samp_lo_we = 1; samp_byte = s[7:0];
    tick();
    samp_lo_we = 0;
    if (collide) begin
      for (int k = 0; k < 70000 && int'(tmr_cnt) != m_per; k++) tick();
    end
    samp_hi_we = 1; samp_byte = s[15:8];
    tick();
    samp_hi_we = 0;
  endtask

  task automatic setup(input int p);
    mod_en = 0; tmr_run = 0; tick();
    cnt_clr = 1; tick(); cnt_clr = 0;
    period_we = 1; period_in = 16'(p); tick(); period_we = 0;
    write_sample(16'h0000, 0); tick();
    tmr_run = 1; tick();
    mod_en = 1;
  endtask

  initial begin
    int periods[3] = '{0, 2, 5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 count", int'(tmr_cnt), 0);
    chk("R1 req", int'(sample_req), 0);
    chk("R1 pdm", int'(pdm_out), 0);
    rst_n = 1;
    tag = "R1"; tick();

    foreach (periods[pi]) begin
      tag = "R2"; setup(periods[pi]);
      for (int i = 0; i < 26; i++) begin
        logic [15:0] s;
        s = 16'(i * 16'h0A73);
        if (i == 24) s = 16'h7FFF;
        if (i == 25) s = 16'h8000;
        tag = (i % 3 == 0) ? "R7" : "R6";
        write_sample(s, i % 3 == 0);
        tag = "R8";
        repeat (2 * (periods[pi] + 1) + 3) tick();
      end
      // R5: only bits 1:0 differ, the model masks them.
      tag = "R5"; write_sample(16'h1233, 0); repeat (12) tick();
      write_sample(16'h1230, 0); repeat (12) tick();
      // R4: a lone low-byte write has no effect on the output stream.
      tag = "R4";
      samp_lo_we = 1; samp_byte = 8'hA5; tick(); samp_lo_we = 0;
      repeat (3 * (periods[pi] + 1) + 4) tick();
      // R6: stopped counter lets the buffer through at once.
      tag = "R6"; tmr_run = 0; write_sample(16'hC004, 0); repeat (6) tick();
      tmr_run = 1; repeat (8) tick();
    end

    // R9: disable clears, then a zero sample alternates 32 of 64.
    tag = "R9";
    write_sample(16'h0000, 0);
    repeat (20) tick();
    mod_en = 0; repeat (4) tick();
    chk("R9 pdm low while off", int'(pdm_out), 0);
    mod_en = 1;
    begin
      int ones = 0;
      for (int k = 0; k < 64; k++) begin
        tick();
        ones += int'(pdm_out);
      end
      chk("R9 density after re-enable", ones, 32);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule